// File: doc/BRIEF.md
# Ping-Pong Chunk Transfer Buffer

This block sits between a 16-bit host register port and a byte-wide bus handshake engine. It holds two byte FIFOs that trade roles. The host fills or drains one of them while the bus side moves bytes through the other. Each chunk of the transfer is described by a 16-bit byte count, which the host writes one byte at a time. A separate strobe write then arms the chunk. A completion flag in the status word reports when the bus side has moved the armed number of bytes.

A direction input picks the mode. In transmit mode the host loads bytes and the bus engine pulls them. In receive mode the bus engine pushes bytes and the host reads them back. A second count can be armed while a chunk is still running. That count starts on the cycle the running chunk finishes, so the bus side never sits idle between chunks. Status shows empty and full for both the host-side buffer and the bus-side buffer.

Top module: `xfer_pingpong_fifo`

## Requirements
- R1: The asynchronous reset empties both buffers, zeroes the count register and clears every flag. After reset the status word reads 0x0028 and both count halves read 0.
- R2: Host address 0 is the data port. A write stores wdata[7:0] first and wdata[15:8] second in the host-side buffer. A read removes up to two bytes and returns the older byte in bits 7:0. When only one byte is present, the read returns that byte with bits 15:8 at zero and removes only that byte.
- R3: Address 1 holds the count high byte and address 2 holds the count low byte. Each is written from wdata[7:0] and reads back. A write to address 3 arms a chunk. Arming with a count of zero is ignored. A count above DEPTH is clamped to DEPTH.
- R4: In transmit mode (dir_rx_i=0), arming while idle hands the host-side buffer to the bus side on the next cycle. The bus side then presents the bytes in write order on bus_dout_o, one byte per accepted strobe, until exactly the armed count has been moved.
- R5: In receive mode (dir_rx_i=1), each accepted strobe stores bus_din_i in the bus-side buffer. When the chunk finishes, that buffer becomes the host-side buffer.
- R6: The done flag (status bit 0) is set on the cycle after the final byte of a chunk is moved. Arming a chunk clears it.
- R7: Arming while a chunk is active records a pending count (status bit 2). When the running chunk finishes, the pending count starts on that same edge and the buffers swap.
- R8: When a transmit chunk finishes, any bytes left in its buffer are discarded. For an odd count this drops the unused high byte of the last word.
- R9: The status word shows host-side empty (bit 3), host-side full (bit 4), bus-side empty (bit 5) and bus-side full (bit 6). Bit 1 shows that a chunk is active and bit 7 shows which buffer the host holds. A host write into a buffer with fewer than two free bytes stores only what fits, low byte first.
- R10: bus_req_o is low when no chunk is active. It is also low in transmit mode while the bus-side buffer is empty, and in receive mode while that buffer is full. A strobe while bus_req_o is low has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| dir_rx_i | input | 1 | 1 = bus to host, 0 = host to bus |
| host_we_i | input | 1 | Host write enable |
| host_re_i | input | 1 | Host read enable (pops only at the data address) |
| host_addr_i | input | 2 | Register select: 0 data, 1 count high, 2 count low, 3 arm/status |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data for the selected register |
| bus_req_o | output | 1 | The bus side can move one byte now |
| bus_strobe_i | input | 1 | Bus engine moves one byte this cycle |
| bus_dout_o | output | 8 | Byte offered to the bus engine in transmit mode |
| bus_din_i | input | 8 | Byte from the bus engine in receive mode |

## Verification
On every cycle, the assertions check the following. No buffer ever overruns or underruns. bus_req_o stays low while no chunk is active. The done flag follows each finish and clears on a later arm. A pending count starts a new chunk on the finishing edge. Buffers swap at chunk start in transmit mode and at chunk finish in receive mode. A finished transmit buffer is left empty. Only the bench scenarios can show byte order through the 16-bit port, the clamp and the zero-count case, the single-byte read, the drop on a full write, and back-to-back chunks where the pending count runs on the swapped buffer with no gap.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
  typedef enum logic [1:0] {
    REG_DATA   = 2'd0,
    REG_CNT_HI = 2'd1,
    REG_CNT_LO = 2'd2,
    REG_CTRL   = 2'd3
  } reg_addr_e;

  localparam int ST_DONE    = 0;
  localparam int ST_ACTIVE  = 1;
  localparam int ST_PENDING = 2;
  localparam int ST_H_EMPTY = 3;
  localparam int ST_H_FULL  = 4;
  localparam int ST_B_EMPTY = 5;
  localparam int ST_B_FULL  = 6;
  localparam int ST_H_SEL   = 7;
endpackage

// File: rtl/xfer_byte_fifo.sv
module xfer_byte_fifo #(
  parameter int DEPTH = 16
) (
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         flush_i,
  input  logic [1:0]                   push_n_i,
  input  logic [15:0]                  push_data_i,
  input  logic [1:0]                   pop_n_i,
  output logic [15:0]                  head_o,
  output logic [$clog2(DEPTH+1)-1:0]   level_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH+1);

  logic [7:0]    mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q, wr_nx, rd_nx;
  logic [CW-1:0] lvl_q;

  assign wr_nx   = wr_q + AW'(1);
  assign rd_nx   = rd_q + AW'(1);
  assign head_o  = {mem[rd_nx], mem[rd_q]};
  assign level_o = lvl_q;

  always_ff @(posedge clk_i) begin
    if (push_n_i != 2'd0) mem[wr_q]  <= push_data_i[7:0];
    if (push_n_i == 2'd2) mem[wr_nx] <= push_data_i[15:8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      lvl_q <= '0;
    end else if (flush_i) begin
      rd_q  <= wr_q;
      lvl_q <= '0;
    end else begin
      wr_q  <= wr_q + AW'(push_n_i);
      rd_q  <= rd_q + AW'(pop_n_i);
      lvl_q <= lvl_q + CW'(push_n_i) - CW'(pop_n_i);
    end
  end

  a_r9_no_overflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(push_n_i) + int'(lvl_q) - int'(pop_n_i) <= DEPTH);
  a_r2_no_underflow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(pop_n_i) <= int'(lvl_q));
endmodule

// File: rtl/xfer_chunk_ctl.sv
module xfer_chunk_ctl #(
  parameter int DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_hi_i,
  input  logic        wr_lo_i,
  input  logic [7:0]  wbyte_i,
  input  logic        arm_i,
  input  logic        beat_i,
  output logic [15:0] cnt_o,
  output logic        active_o,
  output logic        pending_o,
  output logic        done_o,
  output logic        start_o,
  output logic        finish_o
);
  localparam int CW = $clog2(DEPTH+1);

  logic [15:0]   cnt_q;
  logic [CW-1:0] rem_q, pcnt_q, eff;
  logic          active_q, pend_q, done_q;
  logic          arm_ok, finish, launch_now, launch_pend;

  assign eff         = (cnt_q > 16'(DEPTH)) ? CW'(DEPTH) : CW'(cnt_q);
  assign arm_ok      = arm_i && (cnt_q != 16'd0);
  assign finish      = active_q && beat_i && (rem_q == CW'(1));
  assign launch_pend = finish && pend_q;
  assign launch_now  = arm_ok && (!active_q || (finish && !pend_q));

  assign cnt_o     = cnt_q;
  assign active_o  = active_q;
  assign pending_o = pend_q;
  assign done_o    = done_q;
  assign start_o   = launch_now || launch_pend;
  assign finish_o  = finish;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      rem_q    <= '0;
      pcnt_q   <= '0;
      active_q <= 1'b0;
      pend_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      if (wr_hi_i) cnt_q[15:8] <= wbyte_i;
      if (wr_lo_i) cnt_q[7:0]  <= wbyte_i;

      if (launch_pend)                 rem_q <= pcnt_q;
      else if (launch_now)             rem_q <= eff;
      else if (active_q && beat_i)     rem_q <= rem_q - CW'(1);

      if (launch_pend) begin
        pend_q <= arm_ok;
        pcnt_q <= eff;
      end else if (arm_ok && active_q && !finish) begin
        pend_q <= 1'b1;
        pcnt_q <= eff;
      end

      if (launch_now || launch_pend) active_q <= 1'b1;
      else if (finish)               active_q <= 1'b0;

      if (finish)      done_q <= 1'b1;
      else if (arm_ok) done_q <= 1'b0;
    end
  end

  a_r6_done_after_finish: assert property (@(posedge clk_i) disable iff (!rst_ni)
    finish |=> done_o);
  a_r6_arm_clears_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_ok && !finish) |=> !done_o);
  a_r7_pending_launch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (finish && pend_q) |=> active_o);
  a_r3_zero_arm_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (arm_i && cnt_q == 16'd0 && !active_q) |=> !active_o);
endmodule

// File: rtl/xfer_pingpong_fifo.sv
module xfer_pingpong_fifo
  import xfer_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        dir_rx_i,
  input  logic        host_we_i,
  input  logic        host_re_i,
  input  logic [1:0]  host_addr_i,
  input  logic [15:0] host_wdata_i,
  output logic [15:0] host_rdata_o,
  output logic        bus_req_o,
  input  logic        bus_strobe_i,
  output logic [7:0]  bus_dout_o,
  input  logic [7:0]  bus_din_i
);
  localparam int CW = $clog2(DEPTH+1);

  reg_addr_e     addr;
  logic          host_sel_q;
  logic [CW-1:0] lvl  [2];
  logic [15:0]   head [2];
  logic [1:0]    push_n [2];
  logic [1:0]    pop_n  [2];
  logic [15:0]   pdata  [2];
  logic          flush  [2];

  logic [CW-1:0] h_lvl, b_lvl;
  logic [15:0]   h_head, b_head;
  logic [1:0]    h_push_n, h_pop_n, b_push_n, b_pop_n;
  logic          wr_data, rd_data, beat, tx_flush, swap;
  logic [15:0]   cnt;
  logic          active, pending, done, start, finish;
  logic [7:0]    status;

  assign addr   = reg_addr_e'(host_addr_i);
  assign h_lvl  = lvl[host_sel_q];
  assign b_lvl  = lvl[~host_sel_q];
  assign h_head = head[host_sel_q];
  assign b_head = head[~host_sel_q];

  assign wr_data = host_we_i && (addr == REG_DATA);
  assign rd_data = host_re_i && (addr == REG_DATA);

  always_comb begin
    h_push_n = 2'd0;
    if (wr_data) begin
      if (h_lvl <= CW'(DEPTH-2))      h_push_n = 2'd2;
      else if (h_lvl == CW'(DEPTH-1)) h_push_n = 2'd1;
    end
    h_pop_n = 2'd0;
    if (rd_data) begin
      if (h_lvl >= CW'(2))      h_pop_n = 2'd2;
      else if (h_lvl == CW'(1)) h_pop_n = 2'd1;
    end
  end

  assign bus_req_o  = active && (dir_rx_i ? (b_lvl != CW'(DEPTH)) : (b_lvl != '0));
  assign bus_dout_o = b_head[7:0];
  assign beat       = bus_strobe_i && bus_req_o;
  assign b_push_n   = (dir_rx_i && beat)  ? 2'd1 : 2'd0;
  assign b_pop_n    = (!dir_rx_i && beat) ? 2'd1 : 2'd0;
  assign tx_flush   = !dir_rx_i && finish;
  assign swap       = dir_rx_i ? finish : start;

  for (genvar b = 0; b < 2; b++) begin : g_buf
    localparam logic ID = 1'(b);
    assign push_n[b] = (host_sel_q == ID) ? h_push_n : b_push_n;
    assign pop_n[b]  = (host_sel_q == ID) ? h_pop_n  : b_pop_n;
    assign pdata[b]  = (host_sel_q == ID) ? host_wdata_i : {8'h00, bus_din_i};
    assign flush[b]  = (host_sel_q != ID) && tx_flush;

    xfer_byte_fifo #(.DEPTH(DEPTH)) u_buf (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .flush_i     (flush[b]),
      .push_n_i    (push_n[b]),
      .push_data_i (pdata[b]),
      .pop_n_i     (pop_n[b]),
      .head_o      (head[b]),
      .level_o     (lvl[b])
    );
  end

  xfer_chunk_ctl #(.DEPTH(DEPTH)) u_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_hi_i   (host_we_i && (addr == REG_CNT_HI)),
    .wr_lo_i   (host_we_i && (addr == REG_CNT_LO)),
    .wbyte_i   (host_wdata_i[7:0]),
    .arm_i     (host_we_i && (addr == REG_CTRL)),
    .beat_i    (beat),
    .cnt_o     (cnt),
    .active_o  (active),
    .pending_o (pending),
    .done_o    (done),
    .start_o   (start),
    .finish_o  (finish)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) host_sel_q <= 1'b0;
    else if (swap) host_sel_q <= ~host_sel_q;
  end

  always_comb begin
    status             = '0;
    status[ST_DONE]    = done;
    status[ST_ACTIVE]  = active;
    status[ST_PENDING] = pending;
    status[ST_H_EMPTY] = (h_lvl == '0);
    status[ST_H_FULL]  = (h_lvl == CW'(DEPTH));
    status[ST_B_EMPTY] = (b_lvl == '0);
    status[ST_B_FULL]  = (b_lvl == CW'(DEPTH));
    status[ST_H_SEL]   = host_sel_q;
  end

  always_comb begin
    unique case (addr)
      REG_DATA:   host_rdata_o = {(h_lvl >= CW'(2)) ? h_head[15:8] : 8'h00,
                                  (h_lvl >= CW'(1)) ? h_head[7:0]  : 8'h00};
      REG_CNT_HI: host_rdata_o = {8'h00, cnt[15:8]};
      REG_CNT_LO: host_rdata_o = {8'h00, cnt[7:0]};
      default:    host_rdata_o = {8'h00, status};
    endcase
  end

  a_r10_idle_no_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !active |-> !bus_req_o);
  a_r4_tx_start_swaps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_rx_i && start) |=> (host_sel_q != $past(host_sel_q)));
  a_r5_rx_finish_swaps: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dir_rx_i && finish) |=> (host_sel_q != $past(host_sel_q)));
  a_r8_tx_flush_empty: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!dir_rx_i && finish && !pending) |=> (b_lvl == '0));
endmodule

// File: tb/test_xfer_pingpong_fifo.sv
module test_xfer_pingpong_fifo;
  localparam int DEPTH = 16;

  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        dir_rx = 1'b0;
  logic        host_we = 1'b0, host_re = 1'b0;
  logic [1:0]  host_addr = 2'd0;
  logic [15:0] host_wdata = 16'h0, host_rdata;
  logic        bus_req, bus_strobe = 1'b0;
  logic [7:0]  bus_dout, bus_din = 8'h0;

  int n_cmp = 0, n_bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  xfer_pingpong_fifo #(.DEPTH(DEPTH)) i_xfer_pingpong_fifo (
    .clk_i(clk), .rst_ni(rst_ni), .dir_rx_i(dir_rx),
    .host_we_i(host_we), .host_re_i(host_re), .host_addr_i(host_addr),
    .host_wdata_i(host_wdata), .host_rdata_o(host_rdata),
    .bus_req_o(bus_req), .bus_strobe_i(bus_strobe),
    .bus_dout_o(bus_dout), .bus_din_i(bus_din));

  // reference model state
  logic [7:0] q0[$], q1[$];
  int m_hsel, m_cnt, m_active, m_pend, m_pcnt, m_rem, m_done;

  function automatic int qsize(int i);
    return (i == 0) ? q0.size() : q1.size();
  endfunction
  function automatic int qget(int i, int k);
    if (qsize(i) <= k) return 0;
    return (i == 0) ? int'(q0[k]) : int'(q1[k]);
  endfunction
  function automatic void qpush(int i, int v);
    if (i == 0) q0.push_back(8'(v)); else q1.push_back(8'(v));
  endfunction
  function automatic void qpop(int i);
    if (i == 0) void'(q0.pop_front()); else void'(q1.pop_front());
  endfunction
  function automatic void qclear(int i);
    if (i == 0) q0.delete(); else q1.delete();
  endfunction

  function automatic void model_reset();
    q0.delete(); q1.delete();
    m_hsel = 0; m_cnt = 0; m_active = 0; m_pend = 0;
    m_pcnt = 0; m_rem = 0; m_done = 0;
  endfunction

  function automatic int m_req();
    int bs = 1 - m_hsel;
    if (m_active == 0) return 0;
    return dir_rx ? int'(qsize(bs) < DEPTH) : int'(qsize(bs) > 0);
  endfunction

  function automatic int m_status();
    int bs = 1 - m_hsel;
    return m_done | (m_active << 1) | (m_pend << 2) |
           (int'(qsize(m_hsel) == 0) << 3) | (int'(qsize(m_hsel) == DEPTH) << 4) |
           (int'(qsize(bs) == 0) << 5) | (int'(qsize(bs) == DEPTH) << 6) |
           (m_hsel << 7);
  endfunction

  function automatic int m_rdata(int a);
    case (a)
      0: return qget(m_hsel, 0) | (qget(m_hsel, 1) << 8);
      1: return (m_cnt >> 8) & 255;
      2: return m_cnt & 255;
      default: return m_status();
    endcase
  endfunction

  task automatic chk(string tag, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic void model_step(bit we, bit re, int a, int wd, bit stb, int din);
    int hs = m_hsel, bs = 1 - m_hsel;
    int beat = int'(stb) & m_req();
    int arm_ok = int'(we && a == 3 && m_cnt != 0);
    int eff = (m_cnt > DEPTH) ? DEPTH : m_cnt;
    int fin = int'(m_active != 0 && beat != 0 && m_rem == 1);
    int l_now, l_pend;
    if (we && a == 0) begin
      if (qsize(hs) < DEPTH) qpush(hs, wd & 255);
      if (qsize(hs) < DEPTH) qpush(hs, (wd >> 8) & 255);
    end
    if (re && a == 0) begin
      if (qsize(hs) > 0) qpop(hs);
      if (qsize(hs) > 0) qpop(hs);
    end
    if (beat != 0) begin
      if (dir_rx) qpush(bs, din); else qpop(bs);
    end
    if (fin != 0 && !dir_rx) qclear(bs);
    l_pend = int'(fin != 0 && m_pend != 0);
    l_now  = int'(arm_ok != 0 && (m_active == 0 || (fin != 0 && m_pend == 0)));
    if (l_pend != 0)                   m_rem = m_pcnt;
    else if (l_now != 0)               m_rem = eff;
    else if (m_active != 0 && beat != 0) m_rem = m_rem - 1;
    if (l_pend != 0) begin
      m_pend = arm_ok; m_pcnt = eff;
    end else if (arm_ok != 0 && m_active != 0 && fin == 0) begin
      m_pend = 1; m_pcnt = eff;
    end
    if (fin != 0) m_done = 1; else if (arm_ok != 0) m_done = 0;
    if (l_now != 0 || l_pend != 0) m_active = 1; else if (fin != 0) m_active = 0;
    if (dir_rx ? (fin != 0) : (l_now != 0 || l_pend != 0)) m_hsel = 1 - m_hsel;
    if (we && a == 1) m_cnt = ((wd & 255) << 8) | (m_cnt & 255);
    if (we && a == 2) m_cnt = (m_cnt & 16'hff00) | (wd & 255);
  endfunction

  task automatic tick(bit we, bit re, int a, int wd, bit stb, int din);
    host_we = we; host_re = re; host_addr = 2'(a);
    host_wdata = 16'(wd); bus_strobe = stb; bus_din = 8'(din);
    #2;
    chk("R10 bus_req", int'(bus_req), m_req());
    if (m_req() != 0 && !dir_rx) chk("R4 bus_dout", int'(bus_dout), qget(1 - m_hsel, 0));
    chk("R2/R3/R9 host_rdata", int'(host_rdata), m_rdata(a));
    model_step(we, re, a, wd, stb, din);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(int a, int wd);        tick(1, 0, a, wd, 0, 0); endtask
  task automatic strobe(int din);           tick(0, 0, 3, 0, 1, din); endtask
  task automatic arm(int c);
    wr(1, c >> 8); wr(2, c & 255); wr(3, 0);
  endtask
  task automatic expect_status(string tag, int exp);
    host_addr = 2'd3; host_we = 0; host_re = 0; bus_strobe = 0; #1;
    chk(tag, int'(host_rdata[7:0]), exp);
  endtask
  task automatic expect_read(string tag, int exp);
    host_addr = 2'd0; host_we = 0; host_re = 0; bus_strobe = 0; #1;
    chk(tag, int'(host_rdata), exp);
    tick(0, 1, 0, 0, 0, 0);
  endtask
  task automatic do_reset();
    rst_ni = 1'b0; model_reset();
    @(posedge clk); @(negedge clk);
    rst_ni = 1'b1;
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    model_reset();
    @(negedge clk); @(negedge clk);
    rst_ni = 1'b1;
    // R1 reset state
    expect_status("R1 status after reset", 8'h28);
    host_addr = 2'd1; #1; chk("R1 count high after reset", int'(host_rdata), 0);

    // R4/R8 transmit, odd count
    dir_rx = 1'b0;
    wr(0, 16'h0201); wr(0, 16'h0403); wr(0, 16'h0605);
    expect_status("R9 host buffer filled", 8'h20);
    wr(1, 0); wr(2, 5);
    host_addr = 2'd2; #1; chk("R3 count low readback", int'(host_rdata), 5);
    wr(3, 0);
    expect_status("R4 tx arm swaps to bus side", 8'h8A);
    for (int k = 0; k < 5; k++) begin
      #1; chk("R4 tx byte order", int'(bus_dout), k + 1);
      strobe(0);
    end
    expect_status("R6/R8 tx done and leftover dropped", 8'hA9);
    #1; chk("R10 no req after chunk", int'(bus_req), 0);
    strobe(0);

    // R5/R2 receive
    dir_rx = 1'b1;
    arm(3);
    expect_status("R6 arm clears done", 8'hAA);
    strobe(8'h11); strobe(8'h22); strobe(8'h33);
    expect_status("R5 rx finish hands buffer to host", 8'h21);
    expect_read("R2 word read low byte first", 16'h2211);
    expect_read("R2 single byte read", 16'h0033);
    expect_status("R2 host buffer drained", 8'h29);

    // R7 pending chunk in transmit
    dir_rx = 1'b0;
    wr(0, 16'h0B0A); wr(0, 16'h0D0C);
    arm(4);
    wr(0, 16'h0F0E);
    arm(2);
    expect_status("R7 pending recorded", 8'h86);
    for (int k = 0; k < 6; k++) begin
      #1; chk("R7 back-to-back bytes", int'(bus_dout), 8'h0A + k);
      strobe(0);
    end
    expect_status("R7 both chunks done", 8'h29);

    // R3 clamp, R9 full, zero count ignored
    dir_rx = 1'b1;
    arm(16'h0100);
    for (int k = 0; k < DEPTH + 4; k++) strobe(8'h40 + k);
    expect_status("R3 clamp to depth, R9 host full", 8'hB1);
    arm(0);
    expect_status("R3 zero count ignored", 8'hB1);
    for (int k = 0; k < DEPTH / 2; k++)
      expect_read("R5 rx data", ((8'h41 + 2 * k) << 8) | (8'h40 + 2 * k));
    expect_status("R9 drained", 8'hA9);

    // R9 overfull host write, then clamp in transmit
    dir_rx = 1'b0;
    for (int k = 0; k < 9; k++) wr(0, ((2 * k + 1) << 8) | (2 * k));
    expect_status("R9 excess write dropped", 8'hB1);
    arm(20);
    for (int k = 0; k < DEPTH; k++) begin
      #1; chk("R4 full chunk order", int'(bus_dout), k);
      strobe(0);
    end
    expect_status("R3 clamped tx finished", 8'h29);

    // R10 starved transmit, then R1 reset clears everything
    wr(0, 16'h5150);
    arm(4);
    strobe(0); strobe(0);
    #1; chk("R10 no req when bus buffer empty", int'(bus_req), 0);
    expect_status("R10 chunk still active", 8'hAA);
    strobe(0);
    wr(0, 16'h7170);
    do_reset();
    expect_status("R1 reset clears both buffers", 8'h28);
    tick(0, 0, 0, 0, 0, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule